// File: doc/BRIEF.md
# EEPROM Image Shadow Loader with Checksum

This block keeps a 64-word shadow copy of a configuration EEPROM and answers host queries from that copy. It talks to the EEPROM through a simple word port: it holds a request with an address, and optionally write data, until the memory returns a one-cycle acknowledge. Read data arrives with that acknowledge. The serial pin protocol of the EEPROM is handled below this port and is not part of the block.

A host asks for an indexed word or for the 48-bit station address. If the shadow holds a valid signature, the answer comes straight from the shadow. If it does not, the block first fetches the whole image, word 0 through word 63, and adds the words into a wrapping 16-bit sum. The image counts as good only when that sum is 0xBABA and the signature field of control word 1 (word 10, bits 15:14) holds the pattern 01. A checksum failure overwrites control word 1 in the shadow with zero, and so does any write the block makes to the EEPROM. Either event makes the next access fetch the image again.

The host can also ask the block to repair the checksum. The block reads words 0 to 62, computes 0xBABA minus their sum modulo 2^16, and writes the result to word 63.

Top module: `ees_loader`

## Requirements
- R1: A fetch reads EEPROM words 0 to 63 in ascending order, one read per word. The memory request and address stay stable until the acknowledge arrives.
- R2: When the wrapping 16-bit sum of the 64 fetched words is 0xBABA and bits 15:14 of word 10 equal 2'b01, load_ok goes to 1 and lookups return the fetched words.
- R3: When the sum is not 0xBABA, load_ok goes to 0 and lookups return 0. Word 10 of the shadow is cleared, so the next access fetches the image again.
- R4: When the sum is 0xBABA but bits 15:14 of word 10 are not 2'b01, load_ok goes to 0 and lookups return 0.
- R5: While the shadow signature is valid, lookups and station-address requests issue no EEPROM reads.
- R6: A lookup with an index of 64 or more returns 0.
- R7: A checksum update reads words 0 to 62 (63 reads), then writes 0xBABA minus their sum to word 63. This is the only write the block ever makes, and it always targets word 63.
- R8: After the checksum write, the shadow signature is invalid and upd_ack pulses. The next access fetches the image again and sees the current EEPROM contents.
- R9: A station-address request returns {word2, word1, word0}, so the first address byte (the low byte of word 0) sits in bits 7:0. It returns 0 when the image is not valid.
- R10: After reset, all acknowledges, mem_req and load_ok are 0, and the shadow is not valid.
- R11: Requests that arrive in the same idle cycle are served in priority order: lookup first, then station address, then update. Only the winner is acknowledged. At most one acknowledge is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_req | input | 1 | One-cycle pulse requesting a word lookup |
| lookup_idx | input | 8 | Word index for the lookup |
| lookup_ack | output | 1 | One-cycle pulse; lookup_data is valid |
| lookup_data | output | 16 | Looked-up word, or 0 |
| addr_req | input | 1 | One-cycle pulse requesting the station address |
| addr_ack | output | 1 | One-cycle pulse; station_addr is valid |
| station_addr | output | 48 | Station address, first byte in bits 7:0, or 0 |
| upd_req | input | 1 | One-cycle pulse requesting a checksum repair |
| upd_ack | output | 1 | One-cycle pulse when the checksum write has completed |
| load_ok | output | 1 | Result of the most recent image fetch |
| mem_req | output | 1 | EEPROM word access request, held until mem_ack |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 6 | EEPROM word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | One-cycle completion of the access |
| mem_rdata | input | 16 | Read data, valid with mem_ack |

## Verification
The bench builds the block with its default parameters: a 6-bit word address, which gives a 64-word image, and an 8-bit lookup index. Because the index is two bits wider than the word address, indices from 64 to 255 can reach the block, and the out-of-range zero reply can be exercised. The memory model in the bench counts reads and logs their addresses. This lets the bench check the fetch order, confirm that a valid shadow causes no fetch, and confirm that a cleared signature forces a new fetch. The bench also builds images whose checksum is broken, or whose checksum is correct but whose signature is wrong, to separate the two failure paths.

// File: rtl/ees_pkg.sv
package ees_pkg;
    localparam int          WORD_W     = 16;
    localparam logic [15:0] IMG_SUM    = 16'hBABA;
    localparam logic [15:0] SIG_MASK   = 16'hC000;
    localparam logic [15:0] SIG_GOOD   = 16'h4000;
    localparam logic [15:0] SIG_CLEAR  = 16'h0000;
    localparam int          CTRL1_WORD = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHECK,
        ST_REPLY,
        ST_SUM,
        ST_WRITE
    } state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOOKUP,
        OP_STATION
    } op_e;

    function automatic logic sig_good(input logic [15:0] w);
        return (w & SIG_MASK) == SIG_GOOD;
    endfunction

    function automatic logic [15:0] csum_fix(input logic [15:0] partial);
        return IMG_SUM - partial;
    endfunction
endpackage

// File: rtl/ees_accum.sv
module ees_accum
    import ees_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add_en,
    input  logic [WORD_W-1:0] add_val,
    output logic [WORD_W-1:0] sum_q,
    output logic [WORD_W-1:0] sum_nx
);
    // The sum wraps at 16 bits.
    assign sum_nx = sum_q + add_val;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_nx;
        end
    end
endmodule

// File: rtl/ees_shadow.sv
module ees_shadow
    import ees_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_sig,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] ctrl1_word,
    output logic [47:0]       station
);
    logic [WORD_W-1:0] words [DEPTH];

    // One register per shadow word.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (clr_sig && g == CTRL1_WORD) begin
                words[g] <= SIG_CLEAR;
            end else if (wr_en && wr_addr == AW'(g)) begin
                words[g] <= wr_data;
            end
        end
    end

    assign rd_data    = words[rd_addr];
    assign ctrl1_word = words[CTRL1_WORD];
    assign station    = {words[2], words[1], words[0]};
endmodule

// File: rtl/ees_ctrl.sv
module ees_ctrl
    import ees_pkg::*;
#(
    parameter int AW    = 6,
    parameter int IDX_W = AW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_req,
    input  logic [IDX_W-1:0]  lookup_idx,
    input  logic              addr_req,
    input  logic              upd_req,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] ctrl1_word,
    input  logic [WORD_W-1:0] sum_q,
    input  logic [WORD_W-1:0] sum_nx,
    input  logic [WORD_W-1:0] shadow_rd,
    input  logic [47:0]       shadow_station,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              acc_clear,
    output logic              acc_add,
    output logic              sh_wr_en,
    output logic [AW-1:0]     sh_wr_addr,
    output logic [WORD_W-1:0] sh_wr_data,
    output logic              sh_clr_sig,
    output logic [IDX_W-1:0]  idx_q,
    output logic              lookup_ack,
    output logic [WORD_W-1:0] lookup_data,
    output logic              addr_ack,
    output logic [47:0]       station_addr,
    output logic              upd_ack,
    output logic              load_ok
);
    localparam int               DEPTH   = 1 << AW;
    localparam logic [AW-1:0]    LAST    = AW'(DEPTH - 1);
    localparam logic [AW-1:0]    SUM_END = AW'(DEPTH - 2);
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

    state_e            state;
    op_e               op;
    logic [AW-1:0]     cnt;
    logic [WORD_W-1:0] wdata_q;
    logic              shadow_ok;
    logic              sum_bad;

    assign shadow_ok = sig_good(ctrl1_word);
    assign sum_bad   = (sum_q != IMG_SUM);

    always_comb begin
        mem_req    = (state == ST_LOAD) || (state == ST_SUM) || (state == ST_WRITE);
        mem_we     = (state == ST_WRITE);
        mem_addr   = (state == ST_WRITE) ? LAST : cnt;
        mem_wdata  = wdata_q;
        acc_clear  = (state == ST_IDLE);
        acc_add    = ((state == ST_LOAD) || (state == ST_SUM)) && mem_ack;
        sh_wr_en   = (state == ST_LOAD) && mem_ack;
        sh_wr_addr = cnt;
        sh_wr_data = mem_rdata;
        sh_clr_sig = ((state == ST_CHECK) && sum_bad) ||
                     ((state == ST_WRITE) && mem_ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            op           <= OP_NONE;
            cnt          <= '0;
            idx_q        <= '0;
            wdata_q      <= '0;
            lookup_ack   <= 1'b0;
            lookup_data  <= '0;
            addr_ack     <= 1'b0;
            station_addr <= '0;
            upd_ack      <= 1'b0;
            load_ok      <= 1'b0;
        end else begin
            lookup_ack <= 1'b0;
            addr_ack   <= 1'b0;
            upd_ack    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (lookup_req) begin
                        op    <= OP_LOOKUP;
                        idx_q <= lookup_idx;
                        state <= shadow_ok ? ST_REPLY : ST_LOAD;
                    end else if (addr_req) begin
                        op    <= OP_STATION;
                        state <= shadow_ok ? ST_REPLY : ST_LOAD;
                    end else if (upd_req) begin
                        op    <= OP_NONE;
                        state <= ST_SUM;
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        if (cnt == LAST) state <= ST_CHECK;
                        else             cnt   <= cnt + 1'b1;
                    end
                end
                ST_CHECK: begin
                    load_ok <= !sum_bad && shadow_ok;
                    state   <= ST_REPLY;
                end
                ST_REPLY: begin
                    if (op == OP_LOOKUP) begin
                        lookup_ack  <= 1'b1;
                        lookup_data <= (shadow_ok && idx_q < DEPTH_I) ? shadow_rd : '0;
                    end else begin
                        addr_ack     <= 1'b1;
                        station_addr <= shadow_ok ? shadow_station : '0;
                    end
                    state <= ST_IDLE;
                end
                ST_SUM: begin
                    if (mem_ack) begin
                        if (cnt == SUM_END) begin
                            wdata_q <= csum_fix(sum_nx);
                            state   <= ST_WRITE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        upd_ack <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ees_loader.sv
module ees_loader
    import ees_pkg::*;
#(
    parameter int AW    = 6,
    parameter int IDX_W = AW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_req,
    input  logic [IDX_W-1:0]  lookup_idx,
    output logic              lookup_ack,
    output logic [WORD_W-1:0] lookup_data,
    input  logic              addr_req,
    output logic              addr_ack,
    output logic [47:0]       station_addr,
    input  logic              upd_req,
    output logic              upd_ack,
    output logic              load_ok,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic              acc_clear;
    logic              acc_add;
    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] sum_nx;
    logic              sh_wr_en;
    logic [AW-1:0]     sh_wr_addr;
    logic [WORD_W-1:0] sh_wr_data;
    logic              sh_clr_sig;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] shadow_rd;
    logic [WORD_W-1:0] ctrl1_word;
    logic [47:0]       shadow_station;

    ees_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .clear   (acc_clear),
        .add_en  (acc_add),
        .add_val (mem_rdata),
        .sum_q   (sum_q),
        .sum_nx  (sum_nx)
    );

    ees_shadow #(.AW(AW)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (sh_wr_en),
        .wr_addr    (sh_wr_addr),
        .wr_data    (sh_wr_data),
        .clr_sig    (sh_clr_sig),
        .rd_addr    (idx_q[AW-1:0]),
        .rd_data    (shadow_rd),
        .ctrl1_word (ctrl1_word),
        .station    (shadow_station)
    );

    ees_ctrl #(.AW(AW), .IDX_W(IDX_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .lookup_req     (lookup_req),
        .lookup_idx     (lookup_idx),
        .addr_req       (addr_req),
        .upd_req        (upd_req),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .ctrl1_word     (ctrl1_word),
        .sum_q          (sum_q),
        .sum_nx         (sum_nx),
        .shadow_rd      (shadow_rd),
        .shadow_station (shadow_station),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .acc_clear      (acc_clear),
        .acc_add        (acc_add),
        .sh_wr_en       (sh_wr_en),
        .sh_wr_addr     (sh_wr_addr),
        .sh_wr_data     (sh_wr_data),
        .sh_clr_sig     (sh_clr_sig),
        .idx_q          (idx_q),
        .lookup_ack     (lookup_ack),
        .lookup_data    (lookup_data),
        .addr_ack       (addr_ack),
        .station_addr   (station_addr),
        .upd_ack        (upd_ack),
        .load_ok        (load_ok)
    );
endmodule

// File: rtl/ees_checker.sv
module ees_checker
    import ees_pkg::*;
#(
    parameter int AW    = 6,
    parameter int IDX_W = AW + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              lookup_ack,
    input logic              addr_ack,
    input logic              upd_ack,
    input logic [WORD_W-1:0] lookup_data,
    input logic [IDX_W-1:0]  idx_q,
    input logic [WORD_W-1:0] ctrl1_word,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_ack
);
    localparam int DEPTH = 1 << AW;

    a_r11_one_reply: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lookup_ack, addr_ack, upd_ack}));

    a_r6_range_zero: assert property (@(posedge clk) disable iff (rst)
        (lookup_ack && idx_q >= IDX_W'(DEPTH)) |-> lookup_data == '0);

    a_r3_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        (lookup_ack && !sig_good(ctrl1_word)) |-> lookup_data == '0);

    a_r7_write_last: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_addr == AW'(DEPTH - 1));

    a_r1_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r8_sig_cleared: assert property (@(posedge clk) disable iff (rst)
        upd_ack |-> !sig_good(ctrl1_word));

    a_r8_after_write: assert property (@(posedge clk) disable iff (rst)
        upd_ack |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind ees_loader ees_checker #(.AW(AW), .IDX_W(IDX_W)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .lookup_ack  (lookup_ack),
    .addr_ack    (addr_ack),
    .upd_ack     (upd_ack),
    .lookup_data (lookup_data),
    .idx_q       (idx_q),
    .ctrl1_word  (ctrl1_word),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack)
);

// File: tb/ees_loader_tb.sv
`timescale 1ns/1ps
module ees_loader_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lookup_req = 1'b0;
    logic [7:0]  lookup_idx = '0;
    logic        lookup_ack;
    logic [15:0] lookup_data;
    logic        addr_req = 1'b0;
    logic        addr_ack;
    logic [47:0] station_addr;
    logic        upd_req = 1'b0;
    logic        upd_ack;
    logic        load_ok;
    logic        mem_req;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem [64];
    int          rd_count = 0;
    int          wr_count = 0;
    logic [5:0]  rd_log [256];
    int          checks = 0;
    int          errors = 0;
    logic        finished = 1'b0;

    always #2 clk = ~clk;

    ees_loader u_dut (
        .clk(clk), .rst(rst),
        .lookup_req(lookup_req), .lookup_idx(lookup_idx),
        .lookup_ack(lookup_ack), .lookup_data(lookup_data),
        .addr_req(addr_req), .addr_ack(addr_ack), .station_addr(station_addr),
        .upd_req(upd_req), .upd_ack(upd_ack), .load_ok(load_ok),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Word memory model: one acknowledge per request, one cycle later.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (!rst && mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_count <= wr_count + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                rd_log[rd_count % 256] <= mem_addr;
                rd_count <= rd_count + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_upto(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic build_image(input logic [15:0] seed, input logic [1:0] sig);
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h1357) ^ seed;
        mem[10] = {sig, mem[10][13:0]};
        mem[63] = 16'hBABA - sum_upto(63);
    endtask

    task automatic wait_ack(input int which, output logic got);
        int n = 0;
        got = 1'b0;
        while (n < 2000 && !got) begin
            @(negedge clk);
            n++;
            if (which == 0 && lookup_ack) got = 1'b1;
            if (which == 1 && addr_ack)   got = 1'b1;
            if (which == 2 && upd_ack)    got = 1'b1;
        end
        if (!got) chk(1'b0, "timeout waiting for acknowledge", 48'(which), 48'(which));
    endtask

    task automatic do_lookup(input logic [7:0] idx, output logic [15:0] d);
        logic got;
        @(negedge clk);
        lookup_idx = idx;
        lookup_req = 1'b1;
        @(negedge clk);
        lookup_req = 1'b0;
        wait_ack(0, got);
        d = lookup_data;
    endtask

    task automatic do_station(output logic [47:0] a);
        logic got;
        @(negedge clk);
        addr_req = 1'b1;
        @(negedge clk);
        addr_req = 1'b0;
        wait_ack(1, got);
        a = station_addr;
    endtask

    task automatic do_update();
        logic got;
        @(negedge clk);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        wait_ack(2, got);
    endtask

    task automatic t_reset();
        chk(!lookup_ack && !addr_ack && !upd_ack, "R10 acks low after reset",
            48'({lookup_ack, addr_ack, upd_ack}), 48'(0));
        chk(!mem_req, "R10 mem_req low after reset", 48'(mem_req), 48'(0));
        chk(!load_ok, "R10 load_ok low after reset", 48'(load_ok), 48'(0));
    endtask

    task automatic t_good_load();
        logic [15:0] d;
        int base;
        logic order_ok;
        build_image(16'h2C41, 2'b01);
        base = rd_count;
        do_lookup(8'd17, d);
        chk(rd_count - base == 64, "R1 fetch reads 64 words", 48'(rd_count - base), 48'(64));
        order_ok = 1'b1;
        for (int i = 0; i < 64; i++)
            if (rd_log[(base + i) % 256] != 6'(i)) order_ok = 1'b0;
        chk(order_ok, "R1 fetch in ascending order", 48'(order_ok), 48'(1));
        chk(load_ok, "R2 load_ok after good image", 48'(load_ok), 48'(1));
        chk(d == mem[17], "R2 lookup word 17", 48'(d), 48'(mem[17]));
    endtask

    task automatic t_hit();
        logic [15:0] d;
        logic [47:0] a;
        int base = rd_count;
        do_lookup(8'd63, d);
        chk(d == mem[63], "R5 lookup word 63 from shadow", 48'(d), 48'(mem[63]));
        do_lookup(8'd0, d);
        chk(d == mem[0], "R5 lookup word 0 from shadow", 48'(d), 48'(mem[0]));
        do_station(a);
        chk(rd_count == base, "R5 no reads while shadow valid", 48'(rd_count - base), 48'(0));
        chk(a == {mem[2], mem[1], mem[0]}, "R9 station address", a, {mem[2], mem[1], mem[0]});
    endtask

    task automatic t_range();
        logic [15:0] d;
        do_lookup(8'd64, d);
        chk(d == 16'h0, "R6 index 64 returns 0", 48'(d), 48'(0));
        do_lookup(8'd255, d);
        chk(d == 16'h0, "R6 index 255 returns 0", 48'(d), 48'(0));
    endtask

    task automatic t_priority();
        int la = 0;
        int aa = 0;
        @(negedge clk);
        lookup_idx = 8'd5;
        lookup_req = 1'b1;
        addr_req   = 1'b1;
        @(negedge clk);
        lookup_req = 1'b0;
        addr_req   = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (lookup_ack) la++;
            if (addr_ack)   aa++;
        end
        chk(la == 1 && aa == 0, "R11 lookup wins over address", 48'({la[7:0], aa[7:0]}), 48'(16'h0100));
        chk(lookup_data == mem[5], "R11 winner data", 48'(lookup_data), 48'(mem[5]));
    endtask

    task automatic t_bad_sum();
        logic [15:0] d;
        logic [47:0] a;
        int base;
        build_image(16'h7001, 2'b01);
        mem[5] = mem[5] ^ 16'h0001;
        // The shadow holds the previous image, so an update is used to force a fresh fetch.
        do_update();
        mem[63] = mem[63] ^ 16'h0100;
        base = rd_count;
        do_lookup(8'd3, d);
        chk(rd_count - base == 64, "R3 fetch after invalidation", 48'(rd_count - base), 48'(64));
        chk(!load_ok, "R3 load_ok low on bad sum", 48'(load_ok), 48'(0));
        chk(d == 16'h0, "R3 lookup returns 0 on bad sum", 48'(d), 48'(0));
        base = rd_count;
        do_station(a);
        chk(rd_count - base == 64, "R3 next access fetches again", 48'(rd_count - base), 48'(64));
        chk(a == 48'h0, "R9 station address 0 on bad image", a, 48'(0));
    endtask

    task automatic t_bad_sig();
        logic [15:0] d;
        build_image(16'h0F0F, 2'b10);
        do_lookup(8'd12, d);
        chk(!load_ok, "R4 load_ok low on bad signature", 48'(load_ok), 48'(0));
        chk(d == 16'h0, "R4 lookup returns 0 on bad signature", 48'(d), 48'(0));
    endtask

    task automatic t_update();
        logic [15:0] d;
        logic [15:0] exp63;
        int rbase;
        int wbase;
        build_image(16'h55AA, 2'b01);
        do_lookup(8'd20, d);
        chk(load_ok && d == mem[20], "R2 reload good image", 48'(d), 48'(mem[20]));
        mem[20] = mem[20] + 16'h0123;
        exp63 = 16'hBABA - sum_upto(63);
        rbase = rd_count;
        wbase = wr_count;
        do_update();
        chk(rd_count - rbase == 63, "R7 update reads 63 words", 48'(rd_count - rbase), 48'(63));
        chk(wr_count - wbase == 1, "R7 update writes once", 48'(wr_count - wbase), 48'(1));
        chk(mem[63] == exp63, "R7 checksum word value", 48'(mem[63]), 48'(exp63));
        rbase = rd_count;
        do_lookup(8'd20, d);
        chk(rd_count - rbase == 64, "R8 fetch after write", 48'(rd_count - rbase), 48'(64));
        chk(load_ok && d == mem[20], "R8 new contents seen", 48'(d), 48'(mem[20]));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good_load();
        t_hit();
        t_range();
        t_priority();
        t_bad_sum();
        t_bad_sig();
        t_update();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule